// File: doc/BRIEF.md
# Dual-Width Stack Push Sequencer

This block performs a register push onto a byte-wide memory stack, emitting one byte write per memory handshake. A start strobe captures a 24-bit register value together with the push width. The width comes from a global mode bit and can be overridden per push to force long or short behaviour. A long push writes three bytes below a 24-bit long stack pointer. A short push writes two bytes below a 16-bit short stack pointer, and the 24-bit address is completed with an 8-bit page value placed above the pointer.

The most significant byte is always written first, at the highest address, and each following byte goes one address lower. The pointer that was used moves down by the byte count once the last byte has been accepted, and `done` pulses in that same cycle. Software-side logic can load either pointer while the block is idle.

Top module: `stack_push_seq`

## Requirements
- R1: After reset both pointers read zero, and `busy`, `done` and `memWrite` are low.
- R2: A long push writes value bits [23:16] to address longPtr-1, then bits [15:8] to longPtr-2, then bits [7:0] to longPtr-3, in that order.
- R3: After a long push the long pointer has dropped by three and the short pointer is unchanged.
- R4: A short push writes value bits [15:8] to address {page, shortPtr-1}, then bits [7:0] to {page, shortPtr-2}. Here page is the 8-bit `basePage` captured at start and forms address bits [23:16].
- R5: After a short push the short pointer has dropped by two and the long pointer is unchanged.
- R6: Width selection: `forceLong`=1 gives a long push; otherwise `forceShort`=1 gives a short push; with neither set, `longMode`=1 gives long and 0 gives short.
- R7: `memWrite`, `memAddr` and `memData` hold steady while `memReady` is low. Exactly one byte is accepted per cycle in which both `memWrite` and `memReady` are high.
- R8: Address and pointer arithmetic wraps modulo 2^24 for the long pointer and modulo 2^16 for the short pointer.
- R9: `done` is high for exactly one cycle, the first cycle after the last byte is accepted. In that cycle the updated pointer is visible and `busy` is low.
- R10: A start strobe received while `busy` is high is ignored, and no extra writes follow.
- R11: `longPtrWe`/`shortPtrWe` load their pointer on the next edge only when the block is idle and no start is being accepted. Loads requested while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPush | input | 1 | Start strobe, honoured only when idle |
| regValue | input | 24 | Register value to push |
| longMode | input | 1 | Global width mode: 1 long, 0 short |
| forceLong | input | 1 | Per-push override forcing a long push |
| forceShort | input | 1 | Per-push override forcing a short push |
| basePage | input | 8 | Upper address byte for short pushes |
| longPtrWe | input | 1 | Load enable for the long pointer |
| longPtrIn | input | 24 | Load value for the long pointer |
| shortPtrWe | input | 1 | Load enable for the short pointer |
| shortPtrIn | input | 16 | Load value for the short pointer |
| memAddr | output | 24 | Byte write address |
| memData | output | 8 | Byte write data |
| memWrite | output | 1 | Write strobe |
| memReady | input | 1 | Memory accepts the current byte |
| busy | output | 1 | Push in progress |
| done | output | 1 | One-cycle completion pulse |
| longPtr | output | 24 | Current long stack pointer |
| shortPtr | output | 16 | Current short stack pointer |

## Verification
A corrupted byte index or latched width appears at the ports one cycle after start, as a wrong address or a wrong data byte on the first strobe. A wrong width also shows up as a wrong write count before `done`. A pointer that is committed at the wrong time, or committed to the wrong register, shows up at the pointer outputs in the same cycle as `done`. A sequencer that advances without a handshake changes `memAddr` during a ready stall, and the bench catches this on the next falling edge.

// File: rtl/stack_push_pkg.sv
package stack_push_pkg;
  typedef enum logic {PS_IDLE, PS_SEND} pushState_e;

  typedef struct packed {
    logic latch;      // capture operands and width
    logic commit;     // final byte accepted: move the pointer
    logic loadLong;   // idle load of the long pointer
    logic loadShort;  // idle load of the short pointer
  } pushCtrl_t;
endpackage

// File: rtl/stack_push_ctrl.sv
module stack_push_ctrl
  import stack_push_pkg::*;
#(
  parameter int IDX_W       = 2,
  parameter int LONG_BYTES  = 3,
  parameter int SHORT_BYTES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPush,
  input  logic             longPtrWe,
  input  logic             shortPtrWe,
  input  logic             memReady,
  input  logic             opLong,
  output pushCtrl_t        ctrl,
  output logic [IDX_W-1:0] byteIdx,
  output logic             memWrite,
  output logic             busy,
  output logic             done
);
  pushState_e       state;
  logic [IDX_W-1:0] lastIdx;
  logic             isIdle;

  assign isIdle   = (state == PS_IDLE);
  assign lastIdx  = opLong ? IDX_W'(LONG_BYTES - 1) : IDX_W'(SHORT_BYTES - 1);
  assign memWrite = (state == PS_SEND);
  assign busy     = (state == PS_SEND);

  always_comb begin
    ctrl.latch     = isIdle && startPush;
    ctrl.commit    = memWrite && memReady && (byteIdx == lastIdx);
    ctrl.loadLong  = isIdle && !startPush && longPtrWe;
    ctrl.loadShort = isIdle && !startPush && shortPtrWe;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= PS_IDLE;
      byteIdx <= '0;
      done    <= 1'b0;
    end else begin
      done <= ctrl.commit;
      if (ctrl.latch) begin
        state   <= PS_SEND;
        byteIdx <= '0;
      end else if (memWrite && memReady) begin
        if (ctrl.commit) begin
          state   <= PS_IDLE;
          byteIdx <= '0;
        end else begin
          byteIdx <= byteIdx + 1'b1;
        end
      end
    end
  end

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R7
  strobe_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memWrite && !memReady) |=> memWrite);

  // R10
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startPush && !memReady) |=> (busy && $stable(byteIdx)));
endmodule

// File: rtl/stack_push_dp.sv
module stack_push_dp
  import stack_push_pkg::*;
#(
  parameter int LONG_W      = 24,
  parameter int SHORT_W     = 16,
  parameter int BYTE_W      = 8,
  parameter int IDX_W       = 2,
  parameter int LONG_BYTES  = 3,
  parameter int SHORT_BYTES = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  pushCtrl_t               ctrl,
  input  logic [LONG_W-1:0]       regValue,
  input  logic                    longMode,
  input  logic                    forceLong,
  input  logic                    forceShort,
  input  logic [LONG_W-SHORT_W-1:0] basePage,
  input  logic [LONG_W-1:0]       longPtrIn,
  input  logic [SHORT_W-1:0]      shortPtrIn,
  input  logic [IDX_W-1:0]        byteIdx,
  input  logic                    memWrite,
  input  logic                    memReady,
  output logic                    opLong,
  output logic [LONG_W-1:0]       memAddr,
  output logic [BYTE_W-1:0]       memData,
  output logic [LONG_W-1:0]       longPtr,
  output logic [SHORT_W-1:0]      shortPtr
);
  localparam int PAGE_W = LONG_W - SHORT_W;

  logic [LONG_W-1:0]  valueQ;
  logic [PAGE_W-1:0]  pageQ;
  logic               opLongQ;
  logic [LONG_W-1:0]  longPtrQ;
  logic [SHORT_W-1:0] shortPtrQ;
  logic               wantLong;
  logic [LONG_W-1:0]  longAddr;
  logic [SHORT_W-1:0] shortAddr;
  logic [IDX_W-1:0]   byteSel;
  logic [BYTE_W-1:0]  valueBytes [LONG_BYTES];

  // override priority: long override, then short override, then mode bit
  assign wantLong = forceLong || (!forceShort && longMode);

  for (genvar g = 0; g < LONG_BYTES; g++) begin : g_bytes
    assign valueBytes[g] = valueQ[g*BYTE_W +: BYTE_W];
  end

  assign longAddr  = longPtrQ - LONG_W'(byteIdx) - LONG_W'(1);
  assign shortAddr = shortPtrQ - SHORT_W'(byteIdx) - SHORT_W'(1);
  assign byteSel   = (opLongQ ? IDX_W'(LONG_BYTES - 1) : IDX_W'(SHORT_BYTES - 1)) - byteIdx;
  assign memAddr   = opLongQ ? longAddr : {pageQ, shortAddr};
  assign memData   = valueBytes[byteSel];
  assign opLong    = opLongQ;
  assign longPtr   = longPtrQ;
  assign shortPtr  = shortPtrQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      valueQ    <= '0;
      pageQ     <= '0;
      opLongQ   <= 1'b0;
      longPtrQ  <= '0;
      shortPtrQ <= '0;
    end else begin
      if (ctrl.latch) begin
        valueQ  <= regValue;
        pageQ   <= basePage;
        opLongQ <= wantLong;
      end
      if (ctrl.commit) begin
        if (opLongQ) longPtrQ  <= longPtrQ - LONG_W'(LONG_BYTES);
        else         shortPtrQ <= shortPtrQ - SHORT_W'(SHORT_BYTES);
      end
      if (ctrl.loadLong)  longPtrQ  <= longPtrIn;
      if (ctrl.loadShort) shortPtrQ <= shortPtrIn;
    end
  end

  // R7
  addr_data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memWrite && !memReady) |=> ($stable(memAddr) && $stable(memData)));

  // R3
  long_keeps_short_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.commit && opLongQ) |=> $stable(shortPtrQ));

  // R5
  short_keeps_long_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.commit && !opLongQ) |=> $stable(longPtrQ));
endmodule

// File: rtl/stack_push_seq.sv
module stack_push_seq
  import stack_push_pkg::*;
#(
  parameter int LONG_W  = 24,
  parameter int SHORT_W = 16,
  parameter int BYTE_W  = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      startPush,
  input  logic [LONG_W-1:0]         regValue,
  input  logic                      longMode,
  input  logic                      forceLong,
  input  logic                      forceShort,
  input  logic [LONG_W-SHORT_W-1:0] basePage,
  input  logic                      longPtrWe,
  input  logic [LONG_W-1:0]         longPtrIn,
  input  logic                      shortPtrWe,
  input  logic [SHORT_W-1:0]        shortPtrIn,
  output logic [LONG_W-1:0]         memAddr,
  output logic [BYTE_W-1:0]         memData,
  output logic                      memWrite,
  input  logic                      memReady,
  output logic                      busy,
  output logic                      done,
  output logic [LONG_W-1:0]         longPtr,
  output logic [SHORT_W-1:0]        shortPtr
);
  localparam int LONG_BYTES  = LONG_W / BYTE_W;
  localparam int SHORT_BYTES = SHORT_W / BYTE_W;
  localparam int IDX_W       = $clog2(LONG_BYTES);

  pushCtrl_t        ctrl;
  logic [IDX_W-1:0] byteIdx;
  logic             opLong;

  stack_push_ctrl #(
    .IDX_W(IDX_W), .LONG_BYTES(LONG_BYTES), .SHORT_BYTES(SHORT_BYTES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .startPush(startPush),
    .longPtrWe(longPtrWe), .shortPtrWe(shortPtrWe),
    .memReady(memReady), .opLong(opLong), .ctrl(ctrl),
    .byteIdx(byteIdx), .memWrite(memWrite), .busy(busy), .done(done)
  );

  stack_push_dp #(
    .LONG_W(LONG_W), .SHORT_W(SHORT_W), .BYTE_W(BYTE_W), .IDX_W(IDX_W),
    .LONG_BYTES(LONG_BYTES), .SHORT_BYTES(SHORT_BYTES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .regValue(regValue),
    .longMode(longMode), .forceLong(forceLong), .forceShort(forceShort),
    .basePage(basePage), .longPtrIn(longPtrIn), .shortPtrIn(shortPtrIn),
    .byteIdx(byteIdx), .memWrite(memWrite), .memReady(memReady),
    .opLong(opLong), .memAddr(memAddr), .memData(memData),
    .longPtr(longPtr), .shortPtr(shortPtr)
  );
endmodule

// File: tb/sim_stack_push_seq.sv
module sim_stack_push_seq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startPush = 1'b0;
  logic [23:0] regValue = '0;
  logic        longMode = 1'b0, forceLong = 1'b0, forceShort = 1'b0;
  logic [7:0]  basePage = '0;
  logic        longPtrWe = 1'b0, shortPtrWe = 1'b0;
  logic [23:0] longPtrIn = '0;
  logic [15:0] shortPtrIn = '0;
  logic [23:0] memAddr;
  logic [7:0]  memData;
  logic        memWrite;
  logic        memReady = 1'b0;
  logic        busy, done;
  logic [23:0] longPtr;
  logic [15:0] shortPtr;

  int checks = 0, failures = 0;
  int readyDelay = 0, waitCnt = 0, logCount = 0, holdErr = 0;
  bit runEnded = 0;
  logic [23:0] logAddr [8];
  logic [7:0]  logData [8];
  logic [23:0] expLong = '0;
  logic [15:0] expShort = '0;

  always #2 clk = ~clk;

  stack_push_seq u0 (
    .clk(clk), .rstN(rstN), .startPush(startPush), .regValue(regValue),
    .longMode(longMode), .forceLong(forceLong), .forceShort(forceShort),
    .basePage(basePage), .longPtrWe(longPtrWe), .longPtrIn(longPtrIn),
    .shortPtrWe(shortPtrWe), .shortPtrIn(shortPtrIn), .memAddr(memAddr),
    .memData(memData), .memWrite(memWrite), .memReady(memReady),
    .busy(busy), .done(done), .longPtr(longPtr), .shortPtr(shortPtr)
  );

  // memory responder: raises ready after readyDelay stall cycles, logs bytes
  initial begin
    logic        prevStall;
    logic [23:0] prevAddr;
    logic [7:0]  prevData;
    prevStall = 0; prevAddr = '0; prevData = '0;
    forever begin
      @(negedge clk);
      if (prevStall && (!memWrite || memAddr != prevAddr || memData != prevData))
        holdErr++;
      prevStall = 0;
      if (memWrite) begin
        if (waitCnt < readyDelay) begin
          memReady = 1'b0;
          waitCnt++;
          prevStall = 1; prevAddr = memAddr; prevData = memData;
        end else begin
          memReady = 1'b1;
          waitCnt = 0;
          if (logCount < 8) begin
            logAddr[logCount] = memAddr;
            logData[logCount] = memData;
          end
          logCount++;
        end
      end else begin
        memReady = 1'b0;
        waitCnt = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic testReset();
    chk(longPtr == 0, "R1 longPtr", 32'(longPtr), 0);
    chk(shortPtr == 0, "R1 shortPtr", 32'(shortPtr), 0);
    chk({busy, done, memWrite} == 3'b000, "R1 busy/done/memWrite", 32'({busy, done, memWrite}), 0);
  endtask

  task automatic loadPtrs(input logic [23:0] l, input logic [15:0] s);
    @(negedge clk);
    longPtrWe = 1; longPtrIn = l; shortPtrWe = 1; shortPtrIn = s;
    @(negedge clk);
    longPtrWe = 0; shortPtrWe = 0;
    expLong = l; expShort = s;
    chk(longPtr == l, "R11 long load", 32'(longPtr), 32'(l));
    chk(shortPtr == s, "R11 short load", 32'(shortPtr), 32'(s));
  endtask

  // one push scenario; disturb pulses start and pointer loads while busy
  task automatic runPush(input logic [23:0] v, input bit lm, input bit fl, input bit fs,
                         input logic [7:0] page, input int dly, input bit disturb, input string tag);
    bit isLong;
    int n;
    bit gotDone;
    logic [23:0] ea;
    logic [7:0]  ed;
    isLong = fl || (!fs && lm);
    n = isLong ? 3 : 2;
    holdErr = 0;
    @(negedge clk);
    logCount = 0; readyDelay = dly;
    regValue = v; longMode = lm; forceLong = fl; forceShort = fs; basePage = page;
    startPush = 1;
    @(negedge clk);
    startPush = 0;
    chk(busy == 1, {tag, " busy after start"}, 32'(busy), 1);
    if (disturb) begin
      startPush = 1; regValue = ~v; longMode = ~lm; forceLong = 0; forceShort = ~fs;
      basePage = ~page; longPtrWe = 1; longPtrIn = 24'h5A5A5A; shortPtrWe = 1; shortPtrIn = 16'hA5A5;
    end
    gotDone = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      startPush = 0; longPtrWe = 0; shortPtrWe = 0;
      if (done) begin gotDone = 1; break; end
    end
    chk(gotDone, {tag, " R9 done seen"}, 32'(gotDone), 1);
    chk(logCount == n, {tag, " R7 byte count"}, 32'(logCount), 32'(n));
    for (int k = 0; k < 3; k++) begin
      if (k < n) begin
        ed = v[8*(n-1-k) +: 8];
        ea = isLong ? (expLong - 24'(k + 1)) : {page, 16'(expShort - 16'(k + 1))};
        chk(logAddr[k] == ea, {tag, isLong ? " R2 addr" : " R4 addr"}, 32'(logAddr[k]), 32'(ea));
        chk(logData[k] == ed, {tag, isLong ? " R2 data" : " R4 data"}, 32'(logData[k]), 32'(ed));
      end
    end
    if (isLong) expLong = expLong - 24'd3;
    else        expShort = expShort - 16'd2;
    chk(longPtr == expLong, {tag, isLong ? " R3 longPtr" : " R5 longPtr"}, 32'(longPtr), 32'(expLong));
    chk(shortPtr == expShort, {tag, isLong ? " R3 shortPtr" : " R5 shortPtr"}, 32'(shortPtr), 32'(expShort));
    chk(busy == 0, {tag, " R9 busy low with done"}, 32'(busy), 0);
    chk(holdErr == 0, {tag, " R7 hold during stall"}, 32'(holdErr), 0);
    @(negedge clk);
    chk(done == 0, {tag, " R9 done one cycle"}, 32'(done), 0);
    if (disturb) begin
      repeat (3) @(negedge clk);
      chk(logCount == n, {tag, " R10 no extra writes"}, 32'(logCount), 32'(n));
      chk(busy == 0, {tag, " R10 stays idle"}, 32'(busy), 0);
      chk(longPtr == expLong, {tag, " R11 busy load ignored"}, 32'(longPtr), 32'(expLong));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    loadPtrs(24'h001000, 16'h8000);
    runPush(24'hABCDEF, 1, 0, 0, 8'h5A, 0, 0, "R2 long");
    runPush(24'h123456, 0, 0, 0, 8'h5A, 0, 0, "R4 short");
    runPush(24'h778899, 0, 1, 0, 8'h11, 1, 0, "R6 forceLong");
    runPush(24'h445566, 1, 0, 1, 8'h22, 3, 0, "R6 forceShort");
    runPush(24'hC0FFEE, 0, 1, 1, 8'h33, 0, 0, "R6 both");
    runPush(24'h0A0B0C, 1, 0, 0, 8'h44, 2, 1, "R10 disturb");
    runPush(24'h0D0E0F, 0, 0, 0, 8'h55, 2, 1, "R10 short disturb");
    loadPtrs(24'h000001, 16'h0001);
    runPush(24'hF1F2F3, 1, 0, 0, 8'h66, 0, 0, "R8 long wrap");
    runPush(24'hE1E2E3, 0, 0, 0, 8'h77, 1, 0, "R8 short wrap");
    runEnded = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!runEnded) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule